// File: doc/BRIEF.md
# PWM Dimming Phase-Sweep Sequencer

This block converts a lamp dimming waveform into a ramped phase-shift command for a full-bridge inverter. While the lamps are lit, the command tracks the live regulation level from the lamp current loop and keeps a copy of it. When the dimming waveform asks for the lamps to go dark, the block opens the loop and freezes that copy. It then steps the command down to a minimum phase, waits there, and steps it back up. The loop closes again only when the rising command meets the frozen value. The switching frequency is never touched; only the phase moves.

The dimming waveform is active low: a low level means lamps lit. It comes from one of two sources. In master mode, an internal counter-based generator produces it from a duty word, with a floor on the duty. In slave mode, it is taken from an input pin. Dimming only acts once the ignition frequency sweep has finished and while no internal fault is flagged. Otherwise the lamps stay lit with the loop closed. A ramp in progress completes in full before the opposite ramp may start. This interlock keeps deep dimming from extinguishing the lamps when the lit interval is shorter than the ramp.

Top module: `psw_dim_sequencer`

## Requirements
- R1: While reset is asserted, `phase_cmd_o` is 0, `loop_closed_o` is 1, and in master mode `pwm_n_o` is 1.
- R2: When dimming is disabled (`ign_done_i`=0 or `fault_i`=1) and the loop is closed, the dimming level has no effect. `loop_closed_o` stays 1, and `phase_cmd_o` equals the `reg_level_i` value of the previous cycle.
- R3: With dimming enabled and the loop closed, a selected dimming level of 1 (lamps off) makes `loop_closed_o` 0 at the next edge. A level of 0 keeps the loop closed.
- R4: While sweeping down, `phase_cmd_o` falls by the step each cycle and saturates at MIN_PHASE. The held level stays frozen, and `reg_level_i` is ignored.
- R5: At MIN_PHASE, the command waits while the level is 1. After the level goes to 0, it rises by the step each cycle and saturates at the held level. If the held level is below MIN_PHASE, the first rising step lands on the held level directly.
- R6: `loop_closed_o` returns to 1 in the cycle in which `phase_cmd_o` equals the held level. From the next edge on, the command again tracks `reg_level_i`.
- R7: A sweep in progress always completes. A level of 1 during a rising sweep does not start a new fall until the held level is reached and one closed-loop cycle has passed. A level of 0 during a falling sweep does not stop the fall.
- R8: The step equals `rate_i`, and a `rate_i` of 0 is treated as a step of 1.
- R9: In master mode, `pwm_n_o` is 0 for max(`duty_i`, MIN_DUTY) cycles out of every 2^CNT_W cycles, and this waveform drives the sequencer. In slave mode, `pwm_n_o` equals `dim_n_i`.
- R10: If dimming becomes disabled while the loop is open, the command rises to the held level and the loop closes and stays closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ign_done_i | input | 1 | Ignition sweep has reached minimum frequency |
| fault_i | input | 1 | Internal fault present |
| master_mode_i | input | 1 | 1: internal generator, 0: external dimming pin |
| duty_i | input | CNT_W | Lamp-on duty for the internal generator |
| dim_n_i | input | 1 | External dimming level, active low |
| reg_level_i | input | PH_W | Live regulation phase from the current loop |
| rate_i | input | PH_W | Phase step per clock while sweeping |
| pwm_n_o | output | 1 | Selected dimming waveform, active low |
| phase_cmd_o | output | PH_W | Phase-shift command |
| loop_closed_o | output | 1 | Current regulation loop connected |

## Verification
Two events can coincide. A rising sweep can reach the held level in the same cycle in which the dimming level already asks for lamps off. Separately, a fault can arrive while the command sits at the minimum phase. The bench provokes the first case by releasing the level for a single cycle after the fall completes. A reference model predicts that the loop closes for exactly one cycle at the held value before the next fall begins, and every cycle is compared against that model. The second case is provoked by raising the fault during the off wait. The model expects the rise to continue to the held level and the loop to stay closed afterwards.

// File: rtl/psw_pkg.sv
package psw_pkg;
  typedef enum logic [1:0] {
    ST_ON   = 2'd0,
    ST_DOWN = 2'd1,
    ST_OFF  = 2'd2,
    ST_UP   = 2'd3
  } seq_state_e;
endpackage

// File: rtl/psw_pwm_gen.sv
module psw_pwm_gen #(
  parameter int CNT_W    = 6,
  parameter int MIN_DUTY = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] duty_i,
  output logic             pwm_n_o
);
  localparam logic [CNT_W-1:0] MIN_D = CNT_W'(MIN_DUTY);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] duty_eff;
  logic             pwm_n_q, pwm_n_d;

  always_comb begin
    duty_eff = (duty_i < MIN_D) ? MIN_D : duty_i;
    cnt_d    = cnt_q + 1'b1;
    pwm_n_d  = ~(cnt_q < duty_eff);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pwm_n_q <= 1'b1;
    end else begin
      cnt_q   <= cnt_d;
      pwm_n_q <= pwm_n_d;
    end
  end

  assign pwm_n_o = pwm_n_q;
endmodule

// File: rtl/psw_seq_fsm.sv
module psw_seq_fsm
  import psw_pkg::*;
#(
  parameter int PH_W      = 8,
  parameter int MIN_PHASE = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dim_en_i,
  input  logic            off_req_i,
  input  logic [PH_W-1:0] phase_d_i,
  input  logic [PH_W-1:0] held_i,
  output seq_state_e      eff_state_o,
  output seq_state_e      state_o
);
  localparam logic [PH_W-1:0] MIN_P = PH_W'(MIN_PHASE);

  seq_state_e state_q, state_d, eff;

  always_comb begin
    eff = state_q;
    if (!dim_en_i && (state_q != ST_ON)) eff = ST_UP;
  end

  always_comb begin
    state_d = eff;
    case (eff)
      ST_ON:   state_d = off_req_i ? ST_DOWN : ST_ON;
      ST_DOWN: state_d = (phase_d_i == MIN_P) ? ST_OFF : ST_DOWN;
      ST_OFF:  state_d = off_req_i ? ST_OFF : ST_UP;
      ST_UP:   state_d = (phase_d_i == held_i) ? ST_ON : ST_UP;
      default: state_d = ST_ON;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_ON;
    else        state_q <= state_d;
  end

  assign eff_state_o = eff;
  assign state_o     = state_q;
endmodule

// File: rtl/psw_ramp.sv
module psw_ramp
  import psw_pkg::*;
#(
  parameter int PH_W      = 8,
  parameter int MIN_PHASE = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  seq_state_e      eff_state_i,
  input  logic [PH_W-1:0] reg_level_i,
  input  logic [PH_W-1:0] rate_i,
  output logic [PH_W-1:0] phase_d_o,
  output logic [PH_W-1:0] phase_q_o,
  output logic [PH_W-1:0] held_q_o
);
  localparam logic [PH_W-1:0] MIN_P = PH_W'(MIN_PHASE);

  logic [PH_W-1:0] phase_q, phase_d, held_q;
  logic [PH_W:0]   step_w, floor_w, sum_w;
  logic            phase_en, held_en;

  always_comb begin
    step_w  = (rate_i == '0) ? (PH_W+1)'(1) : {1'b0, rate_i};
    floor_w = {1'b0, MIN_P} + step_w;
    sum_w   = {1'b0, phase_q} + step_w;
    case (eff_state_i)
      ST_ON:   phase_d = reg_level_i;
      ST_DOWN: phase_d = ({1'b0, phase_q} < floor_w) ? MIN_P
                                                     : phase_q - step_w[PH_W-1:0];
      ST_UP:   phase_d = (sum_w >= {1'b0, held_q}) ? held_q : sum_w[PH_W-1:0];
      default: phase_d = phase_q;
    endcase
    phase_en = (eff_state_i != ST_OFF);
    held_en  = (eff_state_i == ST_ON);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      held_q  <= '0;
    end else begin
      if (phase_en) phase_q <= phase_d;
      if (held_en)  held_q  <= reg_level_i;
    end
  end

  assign phase_d_o = phase_d;
  assign phase_q_o = phase_q;
  assign held_q_o  = held_q;
endmodule

// File: rtl/psw_dim_sequencer.sv
module psw_dim_sequencer
  import psw_pkg::*;
#(
  parameter int PH_W      = 8,
  parameter int CNT_W     = 6,
  parameter int MIN_PHASE = 16,
  parameter int MIN_DUTY  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ign_done_i,
  input  logic             fault_i,
  input  logic             master_mode_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic             dim_n_i,
  input  logic [PH_W-1:0]  reg_level_i,
  input  logic [PH_W-1:0]  rate_i,
  output logic             pwm_n_o,
  output logic [PH_W-1:0]  phase_cmd_o,
  output logic             loop_closed_o
);
  logic [1:0]      rst_sync_q;
  logic            rst_int_n;
  logic            pwm_int_n, dim_sel_n, dim_en, off_req;
  logic [PH_W-1:0] phase_d, phase_q, held_q;
  seq_state_e      eff_state, state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  psw_pwm_gen #(.CNT_W(CNT_W), .MIN_DUTY(MIN_DUTY)) u_pwm (
    .clk(clk), .rst_n(rst_int_n), .duty_i(duty_i), .pwm_n_o(pwm_int_n)
  );

  assign dim_sel_n = master_mode_i ? pwm_int_n : dim_n_i;
  assign dim_en    = ign_done_i & ~fault_i;
  assign off_req   = dim_en & dim_sel_n;

  psw_seq_fsm #(.PH_W(PH_W), .MIN_PHASE(MIN_PHASE)) u_fsm (
    .clk(clk), .rst_n(rst_int_n), .dim_en_i(dim_en), .off_req_i(off_req),
    .phase_d_i(phase_d), .held_i(held_q),
    .eff_state_o(eff_state), .state_o(state_q)
  );

  psw_ramp #(.PH_W(PH_W), .MIN_PHASE(MIN_PHASE)) u_ramp (
    .clk(clk), .rst_n(rst_int_n), .eff_state_i(eff_state),
    .reg_level_i(reg_level_i), .rate_i(rate_i),
    .phase_d_o(phase_d), .phase_q_o(phase_q), .held_q_o(held_q)
  );

  assign pwm_n_o       = dim_sel_n;
  assign phase_cmd_o   = phase_q;
  assign loop_closed_o = (state_q == ST_ON);
endmodule

// File: rtl/psw_dim_checker.sv
module psw_dim_checker
  import psw_pkg::*;
#(
  parameter int PH_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ign_done_i,
  input logic            fault_i,
  input logic            loop_closed_o,
  input logic [PH_W-1:0] phase_cmd_o,
  input seq_state_e      state_q,
  input logic [PH_W-1:0] held_q
);
  AST_IDLE_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    ((!ign_done_i || fault_i) && loop_closed_o) |=> loop_closed_o); // R2

  AST_HELD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!loop_closed_o) |=> $stable(held_q)); // R4

  AST_DOWN_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_DOWN) && $past(state_q == ST_DOWN)) |-> (phase_cmd_o <= $past(phase_cmd_o))); // R4

  AST_UP_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_UP) && $past(state_q == ST_UP)) |-> (phase_cmd_o >= $past(phase_cmd_o))); // R5

  AST_CLOSE_AT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loop_closed_o) |-> (phase_cmd_o == held_q)); // R6

  AST_NO_UP_TO_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_UP) |=> (state_q != ST_DOWN)); // R7
endmodule

bind psw_dim_sequencer psw_dim_checker #(.PH_W(PH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ign_done_i(ign_done_i), .fault_i(fault_i),
  .loop_closed_o(loop_closed_o), .phase_cmd_o(phase_cmd_o),
  .state_q(state_q), .held_q(held_q)
);

// File: tb/tb_psw_dim_sequencer.sv
module tb_psw_dim_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int PH_W = 8, CNT_W = 6, MIN_PHASE = 16, MIN_DUTY = 4;

  logic clk = 1'b0;
  logic rst_n, ign_done, fault, master, dim_n;
  logic [CNT_W-1:0] duty;
  logic [PH_W-1:0]  reg_lvl, rate;
  logic pwm_n, loop_closed;
  logic [PH_W-1:0] phase_cmd;

  int checks = 0, fails = 0;

  typedef struct { int ph; int cl; string tag; } exp_t;
  exp_t sbq[$];

  // reference model: 0 lit, 1 falling, 2 dark, 3 rising
  int ms = 0, mp = 0, mh = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  psw_dim_sequencer #(.PH_W(PH_W), .CNT_W(CNT_W), .MIN_PHASE(MIN_PHASE), .MIN_DUTY(MIN_DUTY)) dut (
    .clk(clk), .rst_n(rst_n), .ign_done_i(ign_done), .fault_i(fault),
    .master_mode_i(master), .duty_i(duty), .dim_n_i(dim_n),
    .reg_level_i(reg_lvl), .rate_i(rate),
    .pwm_n_o(pwm_n), .phase_cmd_o(phase_cmd), .loop_closed_o(loop_closed)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // driver: apply inputs for one cycle, predict outputs after the next edge
  task automatic drive(input bit ig, input bit fl, input bit dn, input int rl, input int rt, input string tag);
    int st, en, off, nxt;
    @(negedge clk);
    ign_done = ig; fault = fl; dim_n = dn; reg_lvl = rl[PH_W-1:0]; rate = rt[PH_W-1:0];
    en  = ig && !fl;
    off = en && dn;
    st  = (rt == 0) ? 1 : rt;
    nxt = ms;
    if (!en && ms != 0) nxt = 3;
    case (nxt)
      0: begin mh = rl; mp = rl; ms = off ? 1 : 0; end
      1: begin mp = (mp < MIN_PHASE + st) ? MIN_PHASE : mp - st; ms = (mp == MIN_PHASE) ? 2 : 1; end
      2: begin ms = off ? 2 : 3; end
      default: begin mp = (mp + st >= mh) ? mh : mp + st; ms = (mp == mh) ? 0 : 3; end
    endcase
    sbq.push_back('{mp, (ms == 0) ? 1 : 0, tag});
  endtask

  // monitor: pop one prediction per edge
  always @(posedge clk) begin
    #2;
    if (sbq.size() > 0) begin
      exp_t e;
      e = sbq.pop_front();
      check({e.tag, " phase"}, int'(phase_cmd), e.ph);
      check({e.tag, " loop"}, int'(loop_closed), e.cl);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int lows, opened;
    rst_n = 1'b0; ign_done = 0; fault = 0; master = 1; dim_n = 1;
    duty = '0; reg_lvl = '0; rate = 8'd10;
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset phase", int'(phase_cmd), 0);
    check("R1 reset loop", int'(loop_closed), 1);
    check("R1 reset pwm", int'(pwm_n), 1);
    @(negedge clk); rst_n = 1'b1; master = 0;
    repeat (4) @(posedge clk);

    // R2: idle tracking, dimming level ignored
    drive(0, 0, 1, 100, 10, "R2 no ignition");
    drive(0, 0, 1, 120, 10, "R2 no ignition");
    drive(1, 1, 1, 90, 10, "R2 fault");
    drive(1, 1, 1, 100, 10, "R2 fault");
    #3; check("R9 slave echo", int'(pwm_n), 1);

    // R3: lit level keeps loop closed
    for (int i = 0; i < 3; i++) drive(1, 0, 0, 100, 10, "R3 lit");
    #3; check("R9 slave echo", int'(pwm_n), 0);
    // R3/R4: fall with reg changing
    drive(1, 0, 1, 100, 10, "R3 off request");
    for (int i = 0; i < 10; i++) drive(1, 0, 1, 50, 10, "R4 fall");
    // R7: level returns low mid-fall is not honoured here (already at min); wait dark
    for (int i = 0; i < 3; i++) drive(1, 0, 1, 50, 10, "R5 dark wait");
    // R5/R6: rise to held 100
    for (int i = 0; i < 10; i++) drive(1, 0, 0, 100, 10, "R5 rise");
    drive(1, 0, 0, 110, 10, "R6 track after close");
    drive(1, 0, 0, 100, 10, "R6 track after close");

    // R7: fall not stopped by lit level, rise not stopped by off level
    drive(1, 0, 1, 100, 10, "R7 start fall");
    for (int i = 0; i < 3; i++) drive(1, 0, 0, 100, 10, "R7 fall completes");
    for (int i = 0; i < 6; i++) drive(1, 0, 1, 100, 10, "R7 fall completes");
    drive(1, 0, 0, 100, 10, "R7 short lit pulse");
    for (int i = 0; i < 14; i++) drive(1, 0, 1, 100, 10, "R7 rise completes then fall");
    for (int i = 0; i < 10; i++) drive(1, 0, 0, 100, 10, "R7 recover");

    // R8: rate zero steps by one
    drive(1, 0, 0, 22, 0, "R8 load");
    for (int i = 0; i < 8; i++) drive(1, 0, 1, 22, 0, "R8 fall by one");
    for (int i = 0; i < 8; i++) drive(1, 0, 0, 22, 0, "R8 rise by one");

    // R5: held below the minimum phase
    drive(1, 0, 0, 5, 10, "R5 low held load");
    for (int i = 0; i < 3; i++) drive(1, 0, 1, 5, 10, "R5 low held fall");
    for (int i = 0; i < 3; i++) drive(1, 0, 0, 5, 10, "R5 low held rise");

    // R10: fault during dark wait
    drive(1, 0, 0, 80, 20, "R10 load");
    for (int i = 0; i < 6; i++) drive(1, 0, 1, 80, 20, "R10 fall");
    for (int i = 0; i < 8; i++) drive(1, 1, 1, 80, 20, "R10 fault rise and hold");
    repeat (3) @(posedge clk);

    // R9: master generator duty with floor
    master = 1; ign_done = 0;
    foreach (duty_set[k]) begin
      duty = duty_set[k][CNT_W-1:0];
      repeat (70) @(posedge clk);
      lows = 0;
      for (int i = 0; i < 64; i++) begin @(posedge clk); #2; if (!pwm_n) lows++; end
      check("R9 master duty", lows, (duty_set[k] < MIN_DUTY) ? MIN_DUTY : duty_set[k]);
    end
    duty = 6'd32; ign_done = 1; fault = 0; reg_lvl = 8'd60; rate = 8'd30;
    opened = 0;
    for (int i = 0; i < 256; i++) begin @(posedge clk); #2; if (!loop_closed) opened++; end
    check("R9 master drives sequencer", (opened > 0) ? 1 : 0, 1);

    repeat (2) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  int duty_set[3] = '{20, 1, 63};
endmodule